// File: doc/BRIEF.md
# Processor Trap Entry State Update

This block computes every architectural register write a core performs when it takes a trap. The core presents a one-cycle request together with the 9-bit trap type and the live values of the trap level, processor state word, hyper-state word, condition codes, address space identifier, window pointer, free-window count, global level, program counter and next program counter. One cycle later the block presents the new value of each affected register together with a one-cycle write-enable for that register.

The work it does per trap:
- raises the trap level and the global level, both with saturation;
- packs the state being saved into a single saved-state word;
- captures both program counters, the hyper-state word and the trap type;
- rewrites the control bits of the processor state word;
- moves the register-window pointer by an amount that depends on the trap type, wrapped to the number of windows.

A request at the trap-level ceiling is still recorded, and it also raises an error flag.

Top module: `trap_entry_unit`

## Requirements
- R1: An accepted request writes the trap level as `cur_tl`+1, saturated at `MAX_TL` (default 6), with `tl_we` high.
- R2: `error_state` is high in the write cycle exactly when `cur_tl` was at or above `MAX_TL` at acceptance, and low otherwise.
- R3: The saved-state word is 43 bits. It holds the global level in 42:40, the condition codes in 39:32, the address space identifier in 31:24, the 13-bit processor state in 20:8 and the window pointer in 4:0. Bits 23:21 and 7:5 are zero.
- R4: `tpc` and `tnpc` take `cur_pc` and `cur_npc`, `htstate` takes `cur_hpstate`, and `tt_out` takes `trap_type`. Each of these has its own write-enable.
- R5: The global level is written as `cur_gl`+1, saturated at `MAX_GL` (default 3).
- R6: The new processor state sets bit 4, clears bit 3, sets bit 2, copies bit 8 into bit 9 and clears bit 1. All other bits keep their incoming values.
- R7: Trap type 0x024 writes the window pointer as `cur_cwp`+1 modulo `NWINDOWS` (default 8).
- R8: Trap types 0x080 to 0x0BF write the window pointer as `cur_cwp`+`cur_cansave`+2 modulo `NWINDOWS`.
- R9: Trap types 0x0C0 to 0x0FF write the window pointer as `cur_cwp`-1 modulo `NWINDOWS`, so 0 becomes `NWINDOWS`-1.
- R10: Any other trap type leaves `cwp_we` low, and `new_cwp` keeps its previous value.
- R11: A request is accepted when `trap_req` is high and `busy` is low. All write-enables, and `busy`, are high for exactly the one cycle after acceptance. A request seen while `busy` is high is ignored.
- R12: During reset all write-enables, `busy`, `error_state` and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap entry request |
| trap_type | input | 9 | Trap type code |
| cur_tl | input | 3 | Current trap level |
| cur_pstate | input | 13 | Current processor state word |
| cur_hpstate | input | 12 | Current hyper-state word |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address space identifier |
| cur_cwp | input | 5 | Current window pointer |
| cur_cansave | input | 5 | Current free-window count |
| cur_gl | input | 3 | Current global level |
| cur_pc | input | ADDR_W | Current program counter |
| cur_npc | input | ADDR_W | Current next program counter |
| busy | output | 1 | Write cycle in progress; new requests are ignored |
| error_state | output | 1 | Trap taken at maximum trap level |
| tl_we | output | 1 | Trap level write-enable |
| new_tl | output | 3 | New trap level |
| tstate_we | output | 1 | Saved-state write-enable |
| tstate | output | 43 | Saved-state word |
| tpc_we | output | 1 | Trap PC write-enable |
| tpc | output | ADDR_W | Saved program counter |
| tnpc_we | output | 1 | Trap next-PC write-enable |
| tnpc | output | ADDR_W | Saved next program counter |
| htstate_we | output | 1 | Saved hyper-state write-enable |
| htstate | output | 12 | Saved hyper-state word |
| tt_we | output | 1 | Trap type write-enable |
| tt_out | output | 9 | Recorded trap type |
| gl_we | output | 1 | Global level write-enable |
| new_gl | output | 3 | New global level |
| pstate_we | output | 1 | Processor state write-enable |
| new_pstate | output | 13 | Rewritten processor state |
| cwp_we | output | 1 | Window pointer write-enable |
| new_cwp | output | 5 | New window pointer |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Window wrap.** It decrements the window pointer from 0 and increments it from 7. It also drives spill sums large enough to pass the window count more than once. A missing or single-stage reduction would produce an out-of-range pointer.
- **Saturation.** It requests traps with the trap level already at the ceiling and the global level already at its maximum. An unsaturated increment would wrap to zero there, and a wrong compare would fail to raise the error flag.
- **Held request.** It holds the request high for several cycles. A design that ignored `busy` would issue back-to-back write pulses.
- **Trap-type boundaries.** It drives types just outside the spill and fill ranges, such as 0x07F and 0x100. A loose decode would issue a window write where none is allowed.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam int TT_W     = 9;
  localparam int TL_W     = 3;
  localparam int GL_W     = 3;
  localparam int PS_W     = 13;
  localparam int HPS_W    = 12;
  localparam int CCR_W    = 8;
  localparam int ASI_W    = 8;
  localparam int CWP_W    = 5;
  localparam int SAVE_W   = 43;

  // Saved-state field positions (consumed by the return-from-trap path)
  localparam int SV_GL_LO   = 40;
  localparam int SV_CCR_LO  = 32;
  localparam int SV_ASI_LO  = 24;
  localparam int SV_PS_LO   = 8;
  localparam int SV_CWP_LO  = 0;

  // Processor state bits touched on entry
  localparam int PS_IE   = 1;
  localparam int PS_PRIV = 2;
  localparam int PS_AM   = 3;
  localparam int PS_PEF  = 4;
  localparam int PS_TLE  = 8;
  localparam int PS_CLE  = 9;

  localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;

  typedef enum logic [1:0] {
    WIN_HOLD  = 2'd0,
    WIN_INC   = 2'd1,
    WIN_SPILL = 2'd2,
    WIN_DEC   = 2'd3
  } win_move_e;

endpackage

// File: rtl/trap_sat_inc.sv
module trap_sat_inc #(
  parameter int W   = 3,
  parameter int MAX = 6
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         at_max
);

  localparam logic [W-1:0] LIMIT = W'(MAX);

  always_comb begin
    at_max = (cur >= LIMIT);
    if (at_max) begin
      nxt = LIMIT;
    end else begin
      nxt = cur + W'(1);
    end
  end

endmodule

// File: rtl/trap_pstate_xform.sv
module trap_pstate_xform
  import trap_entry_pkg::*;
(
  input  logic [PS_W-1:0] ps_in,
  output logic [PS_W-1:0] ps_out
);

  always_comb begin
    ps_out          = ps_in;
    ps_out[PS_PEF]  = 1'b1;
    ps_out[PS_AM]   = 1'b0;
    ps_out[PS_PRIV] = 1'b1;
    ps_out[PS_CLE]  = ps_in[PS_TLE];
    ps_out[PS_IE]   = 1'b0;
  end

endmodule

// File: rtl/trap_state_pack.sv
module trap_state_pack
  import trap_entry_pkg::*;
(
  input  logic [GL_W-1:0]   gl,
  input  logic [CCR_W-1:0]  ccr,
  input  logic [ASI_W-1:0]  asi,
  input  logic [PS_W-1:0]   ps,
  input  logic [CWP_W-1:0]  cwp,
  output logic [SAVE_W-1:0] word
);

  always_comb begin
    word = '0;
    word[SV_GL_LO  +: GL_W]  = gl;
    word[SV_CCR_LO +: CCR_W] = ccr;
    word[SV_ASI_LO +: ASI_W] = asi;
    word[SV_PS_LO  +: PS_W]  = ps;
    word[SV_CWP_LO +: CWP_W] = cwp;
  end

endmodule

// File: rtl/trap_win_adjust.sv
module trap_win_adjust
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8
) (
  input  logic [TT_W-1:0]  tt,
  input  logic [CWP_W-1:0] cwp,
  input  logic [CWP_W-1:0] cansave,
  output logic [CWP_W-1:0] cwp_next,
  output logic             moves
);

  // Largest raw sum: two full 5-bit operands plus two
  localparam int SUM_W   = CWP_W + 2;
  localparam int SUM_MAX = 2 * ((1 << CWP_W) - 1) + 2;
  localparam int STAGES  = SUM_MAX / NWINDOWS;
  localparam logic [SUM_W-1:0] NW_S   = SUM_W'(NWINDOWS);
  localparam bit   IS_POW2 = ((NWINDOWS & (NWINDOWS - 1)) == 0);

  win_move_e         kind;
  logic [SUM_W-1:0]  raw_sum;
  logic [SUM_W-1:0]  reduced;

  always_comb begin
    kind = WIN_HOLD;
    if (tt == TT_CLEAN_WIN) begin
      kind = WIN_INC;
    end else if (tt[8:6] == 3'b010) begin
      kind = WIN_SPILL;
    end else if (tt[8:6] == 3'b011) begin
      kind = WIN_DEC;
    end
  end

  always_comb begin
    unique case (kind)
      WIN_INC:   raw_sum = SUM_W'(cwp) + SUM_W'(1);
      WIN_SPILL: raw_sum = SUM_W'(cwp) + SUM_W'(cansave) + SUM_W'(2);
      WIN_DEC:   raw_sum = SUM_W'(cwp) + NW_S - SUM_W'(1);
      default:   raw_sum = SUM_W'(cwp);
    endcase
  end

  generate
    if (IS_POW2) begin : g_mask
      assign reduced = raw_sum & (NW_S - SUM_W'(1));
    end else begin : g_chain
      logic [SUM_W-1:0] stage [0:STAGES];
      assign stage[0] = raw_sum;
      for (genvar i = 0; i < STAGES; i++) begin : g_sub
        assign stage[i+1] = (stage[i] >= NW_S) ? (stage[i] - NW_S) : stage[i];
      end
      assign reduced = stage[STAGES];
    end
  endgenerate

  assign cwp_next = reduced[CWP_W-1:0];
  assign moves    = (kind != WIN_HOLD);

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int NWINDOWS = 8,
  parameter int MAX_GL   = 3,
  parameter int MAX_TL   = 6,
  parameter int ADDR_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic [8:0]        trap_type,
  input  logic [2:0]        cur_tl,
  input  logic [12:0]       cur_pstate,
  input  logic [11:0]       cur_hpstate,
  input  logic [7:0]        cur_ccr,
  input  logic [7:0]        cur_asi,
  input  logic [4:0]        cur_cwp,
  input  logic [4:0]        cur_cansave,
  input  logic [2:0]        cur_gl,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_npc,
  output logic              busy,
  output logic              error_state,
  output logic              tl_we,
  output logic [2:0]        new_tl,
  output logic              tstate_we,
  output logic [42:0]       tstate,
  output logic              tpc_we,
  output logic [ADDR_W-1:0] tpc,
  output logic              tnpc_we,
  output logic [ADDR_W-1:0] tnpc,
  output logic              htstate_we,
  output logic [11:0]       htstate,
  output logic              tt_we,
  output logic [8:0]        tt_out,
  output logic              gl_we,
  output logic [2:0]        new_gl,
  output logic              pstate_we,
  output logic [12:0]       new_pstate,
  output logic              cwp_we,
  output logic [4:0]        new_cwp
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  // Next-state datapath
  logic              accept;
  logic [TL_W-1:0]   tl_d;
  logic              tl_at_max;
  logic [GL_W-1:0]   gl_d;
  logic              gl_at_max;
  logic [PS_W-1:0]   ps_d;
  logic [SAVE_W-1:0] save_d;
  logic [CWP_W-1:0]  cwp_d;
  logic              cwp_moves;

  assign accept = trap_req & ~busy;

  trap_sat_inc #(.W(TL_W), .MAX(MAX_TL)) u_tl_inc (
    .cur    (cur_tl),
    .nxt    (tl_d),
    .at_max (tl_at_max)
  );

  trap_sat_inc #(.W(GL_W), .MAX(MAX_GL)) u_gl_inc (
    .cur    (cur_gl),
    .nxt    (gl_d),
    .at_max (gl_at_max)
  );

  trap_pstate_xform u_ps (
    .ps_in  (cur_pstate),
    .ps_out (ps_d)
  );

  trap_state_pack u_pack (
    .gl   (cur_gl),
    .ccr  (cur_ccr),
    .asi  (cur_asi),
    .ps   (cur_pstate),
    .cwp  (cur_cwp),
    .word (save_d)
  );

  trap_win_adjust #(.NWINDOWS(NWINDOWS)) u_win (
    .tt       (trap_type),
    .cwp      (cur_cwp),
    .cansave  (cur_cansave),
    .cwp_next (cwp_d),
    .moves    (cwp_moves)
  );

  // Strobe next-state
  logic we_all_d;
  logic cwp_we_d;
  logic err_d;
  logic cwp_en;

  always_comb begin
    we_all_d = accept;
    cwp_we_d = accept & cwp_moves;
    err_d    = accept & tl_at_max;
    cwp_en   = accept & cwp_moves;
  end

  // Strobe registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy        <= 1'b0;
      error_state <= 1'b0;
      tl_we       <= 1'b0;
      tstate_we   <= 1'b0;
      tpc_we      <= 1'b0;
      tnpc_we     <= 1'b0;
      htstate_we  <= 1'b0;
      tt_we       <= 1'b0;
      gl_we       <= 1'b0;
      pstate_we   <= 1'b0;
      cwp_we      <= 1'b0;
    end else begin
      busy        <= we_all_d;
      error_state <= err_d;
      tl_we       <= we_all_d;
      tstate_we   <= we_all_d;
      tpc_we      <= we_all_d;
      tnpc_we     <= we_all_d;
      htstate_we  <= we_all_d;
      tt_we       <= we_all_d;
      gl_we       <= we_all_d;
      pstate_we   <= we_all_d;
      cwp_we      <= cwp_we_d;
    end
  end

  // Data registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      new_tl     <= '0;
      tstate     <= '0;
      tpc        <= '0;
      tnpc       <= '0;
      htstate    <= '0;
      tt_out     <= '0;
      new_gl     <= '0;
      new_pstate <= '0;
    end else if (accept) begin
      new_tl     <= tl_d;
      tstate     <= save_d;
      tpc        <= cur_pc;
      tnpc       <= cur_npc;
      htstate    <= cur_hpstate;
      tt_out     <= trap_type;
      new_gl     <= gl_d;
      new_pstate <= ps_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      new_cwp <= '0;
    end else if (cwp_en) begin
      new_cwp <= cwp_d;
    end
  end

endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
  parameter int NWINDOWS = 8,
  parameter int MAX_GL   = 3,
  parameter int MAX_TL   = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        trap_req,
  input logic        busy,
  input logic [2:0]  cur_tl,
  input logic        tl_we,
  input logic [2:0]  new_tl,
  input logic        error_state,
  input logic        gl_we,
  input logic [2:0]  new_gl,
  input logic        pstate_we,
  input logic [12:0] new_pstate,
  input logic        cwp_we,
  input logic [4:0]  new_cwp
);

  p_tl_sat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tl_we |-> (new_tl <= 3'(MAX_TL)));

  p_tl_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !busy && (cur_tl < 3'(MAX_TL))) |=> (new_tl == $past(cur_tl) + 3'd1));

  p_err_at_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    error_state |-> (tl_we && new_tl == 3'(MAX_TL)));

  p_gl_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gl_we |-> (new_gl <= 3'(MAX_GL)));

  p_pstate_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pstate_we |-> (new_pstate[4] && !new_pstate[3] && new_pstate[2] &&
                   !new_pstate[1] && (new_pstate[9] == new_pstate[8])));

  p_cwp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_we |-> (new_cwp < 5'(NWINDOWS)));

  p_cwp_with_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_we |-> tl_we);

  p_accept_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !busy) |=> (tl_we && busy));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tl_we |=> !tl_we);

  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !gl_we);

endmodule

bind trap_entry_unit trap_entry_checker #(
  .NWINDOWS (NWINDOWS),
  .MAX_GL   (MAX_GL),
  .MAX_TL   (MAX_TL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .trap_req    (trap_req),
  .busy        (busy),
  .cur_tl      (cur_tl),
  .tl_we       (tl_we),
  .new_tl      (new_tl),
  .error_state (error_state),
  .gl_we       (gl_we),
  .new_gl      (new_gl),
  .pstate_we   (pstate_we),
  .new_pstate  (new_pstate),
  .cwp_we      (cwp_we),
  .new_cwp     (new_cwp)
);

// File: tb/trap_entry_unit_tb.sv
`timescale 1ns/1ps
module trap_entry_unit_tb;

  localparam int NW     = 8;
  localparam int MGL    = 3;
  localparam int MTL    = 6;
  localparam int AW     = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trap_req = 1'b0;
  logic [8:0]    trap_type = '0;
  logic [2:0]    cur_tl = '0;
  logic [12:0]   cur_pstate = '0;
  logic [11:0]   cur_hpstate = '0;
  logic [7:0]    cur_ccr = '0;
  logic [7:0]    cur_asi = '0;
  logic [4:0]    cur_cwp = '0;
  logic [4:0]    cur_cansave = '0;
  logic [2:0]    cur_gl = '0;
  logic [AW-1:0] cur_pc = '0;
  logic [AW-1:0] cur_npc = '0;

  logic          busy, error_state, tl_we, tstate_we, tpc_we, tnpc_we;
  logic          htstate_we, tt_we, gl_we, pstate_we, cwp_we;
  logic [2:0]    new_tl, new_gl;
  logic [42:0]   tstate;
  logic [AW-1:0] tpc, tnpc;
  logic [11:0]   htstate;
  logic [8:0]    tt_out;
  logic [12:0]   new_pstate;
  logic [4:0]    new_cwp;

  always #10 clk = ~clk;

  trap_entry_unit #(.NWINDOWS(NW), .MAX_GL(MGL), .MAX_TL(MTL), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .cur_tl(cur_tl), .cur_pstate(cur_pstate), .cur_hpstate(cur_hpstate),
    .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_cwp(cur_cwp),
    .cur_cansave(cur_cansave), .cur_gl(cur_gl), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .busy(busy), .error_state(error_state), .tl_we(tl_we), .new_tl(new_tl),
    .tstate_we(tstate_we), .tstate(tstate), .tpc_we(tpc_we), .tpc(tpc),
    .tnpc_we(tnpc_we), .tnpc(tnpc), .htstate_we(htstate_we), .htstate(htstate),
    .tt_we(tt_we), .tt_out(tt_out), .gl_we(gl_we), .new_gl(new_gl),
    .pstate_we(pstate_we), .new_pstate(new_pstate), .cwp_we(cwp_we), .new_cwp(new_cwp)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_busy, m_we, m_cwp_we, m_err;
  int          m_tl, m_gl, m_cwp;
  logic [63:0] m_tstate, m_tpc, m_tnpc;
  logic [11:0] m_hts;
  logic [8:0]  m_tt;
  logic [12:0] m_ps;
  string       m_cwp_tag = "R10";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_we = 0; m_cwp_we = 0; m_err = 0;
      m_tl = 0; m_gl = 0; m_cwp = 0;
      m_tstate = 0; m_tpc = 0; m_tnpc = 0; m_hts = 0; m_tt = 0; m_ps = 0;
    end else begin
      bit acc;
      acc = trap_req && !m_busy;
      m_we = acc; m_busy = acc; m_cwp_we = 0; m_err = 0;
      if (acc) begin
        m_tl  = (int'(cur_tl) + 1 > MTL) ? MTL : int'(cur_tl) + 1;
        m_err = (int'(cur_tl) >= MTL);
        m_gl  = (int'(cur_gl) + 1 > MGL) ? MGL : int'(cur_gl) + 1;
        m_tstate = (64'(cur_gl) << 40) | (64'(cur_ccr) << 32) | (64'(cur_asi) << 24)
                 | (64'(cur_pstate) << 8) | 64'(cur_cwp);
        m_tpc = cur_pc; m_tnpc = cur_npc; m_hts = cur_hpstate; m_tt = trap_type;
        m_ps = cur_pstate;
        m_ps[4] = 1'b1; m_ps[3] = 1'b0; m_ps[2] = 1'b1; m_ps[9] = cur_pstate[8]; m_ps[1] = 1'b0;
        if (trap_type == 9'h024) begin
          m_cwp = (int'(cur_cwp) + 1) % NW; m_cwp_we = 1; m_cwp_tag = "R7";
        end else if (trap_type >= 9'h080 && trap_type <= 9'h0BF) begin
          m_cwp = (int'(cur_cwp) + int'(cur_cansave) + 2) % NW; m_cwp_we = 1; m_cwp_tag = "R8";
        end else if (trap_type >= 9'h0C0 && trap_type <= 9'h0FF) begin
          m_cwp = (int'(cur_cwp) + NW - 1) % NW; m_cwp_we = 1; m_cwp_tag = "R9";
        end else begin
          m_cwp_tag = "R10";
        end
      end
    end
  end

  bit compare_on = 0;
  always @(negedge clk) begin
    if (compare_on) begin
      chk("R11", "busy", 64'(busy), 64'(m_busy));
      chk("R11", "tl_we", 64'(tl_we), 64'(m_we));
      chk("R11", "we_group", {58'd0, tstate_we, tpc_we, tnpc_we, htstate_we, tt_we, pstate_we},
          {58'd0, {6{m_we}}});
      chk("R2",  "error_state", 64'(error_state), 64'(m_err));
      chk("R1",  "new_tl", 64'(new_tl), 64'(m_tl));
      chk("R5",  "gl_we", 64'(gl_we), 64'(m_we));
      chk("R5",  "new_gl", 64'(new_gl), 64'(m_gl));
      chk("R3",  "tstate", 64'(tstate), m_tstate);
      chk("R4",  "tpc", tpc, m_tpc);
      chk("R4",  "tnpc", tnpc, m_tnpc);
      chk("R4",  "htstate", 64'(htstate), 64'(m_hts));
      chk("R4",  "tt_out", 64'(tt_out), 64'(m_tt));
      chk("R6",  "new_pstate", 64'(new_pstate), 64'(m_ps));
      chk(m_cwp_tag, "cwp_we", 64'(cwp_we), 64'(m_cwp_we));
      chk(m_cwp_tag, "new_cwp", 64'(new_cwp), 64'(m_cwp));
    end
  end

  task automatic set_ctx(input logic [8:0] tt, input logic [2:0] tl, input logic [2:0] gl,
                         input logic [4:0] cwp, input logic [4:0] cs, input logic [12:0] ps);
    trap_type = tt; cur_tl = tl; cur_gl = gl; cur_cwp = cwp; cur_cansave = cs;
    cur_pstate = ps;
    cur_hpstate = 12'($urandom); cur_ccr = 8'($urandom); cur_asi = 8'($urandom);
    cur_pc = {$urandom, $urandom}; cur_npc = {$urandom, $urandom};
  endtask

  task automatic fire(input logic [8:0] tt, input logic [2:0] tl, input logic [2:0] gl,
                      input logic [4:0] cwp, input logic [4:0] cs, input logic [12:0] ps);
    @(posedge clk); #2;
    set_ctx(tt, tl, gl, cwp, cs, ps);
    trap_req = 1'b1;
    @(posedge clk); #2;
    trap_req = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    // R12: reset state
    repeat (2) @(negedge clk);
    chk("R12", "busy_rst", 64'(busy), 64'd0);
    chk("R12", "we_rst", 64'({tl_we, tstate_we, tpc_we, tnpc_we, htstate_we, tt_we, gl_we,
                              pstate_we, cwp_we, error_state}), 64'd0);
    chk("R12", "data_rst", 64'(tstate) | tpc | tnpc | 64'(new_pstate) | 64'(new_cwp)
                           | 64'(new_tl) | 64'(new_gl) | 64'(tt_out) | 64'(htstate), 64'd0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 compare_on = 1;

    fire(9'h024, 3'd0, 3'd0, 5'd7, 5'd0, 13'h0000);   // R7 wrap 7 -> 0
    fire(9'h024, 3'd2, 3'd1, 5'd3, 5'd0, 13'h1FFF);   // R7, R6 all-ones
    fire(9'h085, 3'd1, 3'd2, 5'd5, 5'd3, 13'h0100);   // R8 5+3+2 -> 2, R6 bit8 copy
    fire(9'h0BF, 3'd1, 3'd0, 5'd31, 5'd31, 13'h0A5A); // R8 large sum
    fire(9'h0C0, 3'd3, 3'd3, 5'd0, 5'd0, 13'h0200);   // R9 wrap 0 -> 7, R5 saturate
    fire(9'h0FF, 3'd5, 3'd2, 5'd4, 5'd0, 13'h0F0F);   // R9, R1 5->6
    fire(9'h010, 3'd6, 3'd0, 5'd2, 5'd1, 13'h0123);   // R10 no move, R2 at max
    fire(9'h07F, 3'd7, 3'd1, 5'd1, 5'd1, 13'h0011);   // R10 boundary, R2 above max
    fire(9'h100, 3'd0, 3'd0, 5'd6, 5'd2, 13'h0000);   // R10 boundary

    // R11: held request -> accepted every other cycle
    @(posedge clk); #2;
    set_ctx(9'h0C4, 3'd1, 3'd1, 5'd1, 5'd0, 13'h0044);
    trap_req = 1'b1;
    repeat (5) @(posedge clk);
    #2 trap_req = 1'b0;
    repeat (2) @(posedge clk);

    // Mixed random stimulus
    for (int i = 0; i < 400; i++) begin
      logic [8:0] rt;
      @(posedge clk); #2;
      case ($urandom_range(0, 4))
        0: rt = 9'h024;
        1: rt = 9'h080 + 9'($urandom_range(0, 63));
        2: rt = 9'h0C0 + 9'($urandom_range(0, 63));
        default: rt = 9'($urandom);
      endcase
      set_ctx(rt, 3'($urandom), 3'($urandom), 5'($urandom), 5'($urandom), 13'($urandom));
      trap_req = ($urandom_range(0, 2) != 0);
    end
    @(posedge clk); #2 trap_req = 1'b0;
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
      end
    join_any
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule